// File: doc/BRIEF.md
# Two-Edge Interval Meter

This block times the gap between the rising edges of two unrelated pulse trains, a reference input and a device input. Either one may rise first. Both inputs are asynchronous. Each passes through a synchroniser and an edge detector, so the block reacts only to rising edges and never to how long an input stays high. A gate output goes high at the first edge and low at the other input's edge. A lead flag for each input shows which one came first. While the gate is open, a cycle counter runs. When the gate closes, the count is latched together with a sign bit, and a one-cycle valid strobe marks it.

A gate that stays open too long means an edge was missed or a glitch started it. A timeout closes such a gate, drops the partial count and raises a one-cycle overrun strobe. The next pair of edges is then measured from a clean idle state.

The controller has three states. `ST_IDLE` waits with the gate closed. `ST_REF_LEAD` is entered on a reference edge alone, and `ST_DUT_LEAD` on a device edge alone. The transitions are:
- start-ref: `ST_IDLE` to `ST_REF_LEAD`.
- start-dut: `ST_IDLE` to `ST_DUT_LEAD`.
- tie: both edges in the same cycle, which stays in `ST_IDLE` and reports zero.
- finish: the other input's edge, from either lead state back to `ST_IDLE`.
- expire: the timeout, from either lead state back to `ST_IDLE`.

Top module: `iv_meter`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `gate`, `lead_ref`, `lead_dut`, `span_valid`, `overrun`, `span_ref_led` and `span` are all zero.
- R2: `gate` goes high 3 clock cycles after the clock edge that first samples a rising edge on either input. It goes low 3 cycles after the edge that samples the other input's rising edge.
- R3: While `gate` is high, exactly one lead flag is set: `lead_ref` when the reference rose first, `lead_dut` when the device input did. Both flags clear in the same cycle that `gate` falls.
- R4: When `gate` closes on the other input's edge, `span` holds the number of clock edges between the two sampled rising edges. `span_valid` is high for exactly that one cycle.
- R5: `span_ref_led` is 1 when the reference input led and 0 when the device input led. It is also 0 for a zero result.
- R6: Only rising edges act. Each of the following has no effect on `gate` or the result:
  - an input held high;
  - a falling edge;
  - a second rising edge of the leading input while `gate` is high.
- R7: When both rising edges are sampled on the same clock edge, `gate` stays low, no lead flag is set, `span` becomes 0 and `span_valid` pulses for one cycle.
- R8: If `gate` has been high for `TIMEOUT_CYC` cycles without the other edge, it is forced low. In that cycle `overrun` pulses for one cycle, `span_valid` stays low and `span` keeps its previous value.
- R9: After a timeout, the next pair of edges is measured correctly, in either order.
- R10: `span` and `span_ref_led` hold their values between result strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Asynchronous reference pulse |
| dut_in | input | 1 | Asynchronous device pulse |
| gate | output | 1 | High from the first rising edge to the other input's edge |
| lead_ref | output | 1 | Reference input led the current measurement |
| lead_dut | output | 1 | Device input led the current measurement |
| span | output | CNT_W | Latched interval in clock cycles |
| span_ref_led | output | 1 | Sign of the latched interval: 1 means the reference led |
| span_valid | output | 1 | One-cycle strobe marking a new `span` |
| overrun | output | 1 | One-cycle strobe marking a timeout clear |

## Verification
Each input crosses two synchroniser flops and an edge register. The controller state then follows one edge later. So `gate` and the lead flags change 3 cycles after the clock edge that first samples an input rise. `span_valid`, `span` and `overrun` change 3 cycles after the clock edge that samples the closing edge. The bench drives inputs on falling clock edges and counts rising edges from that point. It samples 1 ns after the edge where a change is due, and it also samples one edge earlier to confirm the output has not moved too soon. The timeout check counts `3 + TIMEOUT_CYC` edges from the leading input's rise to the edge where `gate` must still be high. `overrun` is due on the following edge.

// File: rtl/iv_pkg.sv
package iv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_REF_LEAD = 2'd1,
        ST_DUT_LEAD = 2'd2
    } iv_state_e;

endpackage

// File: rtl/iv_edge_sync.sv
module iv_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise_stb
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[0] <= 1'b0;
                    else     sync_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[i] <= 1'b0;
                    else     sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q   <= 1'b0;
            rise_stb <= 1'b0;
        end else begin
            last_q   <= sync_q[STAGES-1];
            rise_stb <= sync_q[STAGES-1] & ~last_q;
        end
    end

endmodule

// File: rtl/iv_ctrl.sv
module iv_ctrl
    import iv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ref_stb,
    input  logic dut_stb,
    input  logic tmo_hit,
    output logic gate,
    output logic lead_ref,
    output logic lead_dut,
    output logic ev_finish,
    output logic ev_finish_ref,
    output logic ev_tie,
    output logic ev_expire
);

    iv_state_e state_q, state_d;

    // next-state and event decode
    always_comb begin
        state_d       = state_q;
        ev_finish     = 1'b0;
        ev_finish_ref = 1'b0;
        ev_tie        = 1'b0;
        ev_expire     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_stb && dut_stb) begin
                    ev_tie = 1'b1;
                end else if (ref_stb) begin
                    state_d = ST_REF_LEAD;
                end else if (dut_stb) begin
                    state_d = ST_DUT_LEAD;
                end
            end
            ST_REF_LEAD: begin
                if (dut_stb) begin
                    ev_finish     = 1'b1;
                    ev_finish_ref = 1'b1;
                    state_d       = ST_IDLE;
                end else if (tmo_hit) begin
                    ev_expire = 1'b1;
                    state_d   = ST_IDLE;
                end
            end
            ST_DUT_LEAD: begin
                if (ref_stb) begin
                    ev_finish = 1'b1;
                    state_d   = ST_IDLE;
                end else if (tmo_hit) begin
                    ev_expire = 1'b1;
                    state_d   = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // outputs
    always_comb begin
        gate     = 1'b0;
        lead_ref = 1'b0;
        lead_dut = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_REF_LEAD: begin gate = 1'b1; lead_ref = 1'b1; end
            ST_DUT_LEAD: begin gate = 1'b1; lead_dut = 1'b1; end
            default:     ;
        endcase
    end

endmodule

// File: rtl/iv_span_cnt.sv
module iv_span_cnt #(
    parameter int          CNT_W       = 32,
    parameter int unsigned TIMEOUT_CYC = 32'd2250000000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             ev_finish,
    input  logic             ev_finish_ref,
    input  logic             ev_tie,
    input  logic             ev_expire,
    output logic             tmo_hit,
    output logic [CNT_W-1:0] span,
    output logic             span_ref_led,
    output logic             span_valid,
    output logic             overrun
);

    localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TIMEOUT_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tmo_hit = run && (cnt_q == TMO_LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            span         <= '0;
            span_ref_led <= 1'b0;
            span_valid   <= 1'b0;
            overrun      <= 1'b0;
        end else begin
            span_valid <= ev_finish | ev_tie;
            overrun    <= ev_expire;
            if (ev_finish) begin
                span         <= cnt_q + 1'b1;
                span_ref_led <= ev_finish_ref;
            end else if (ev_tie) begin
                span         <= '0;
                span_ref_led <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/iv_meter.sv
module iv_meter #(
    parameter int          CNT_W       = 32,
    parameter int unsigned TIMEOUT_CYC = 32'd2250000000,
    parameter int          SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_in,
    input  logic             dut_in,
    output logic             gate,
    output logic             lead_ref,
    output logic             lead_dut,
    output logic [CNT_W-1:0] span,
    output logic             span_ref_led,
    output logic             span_valid,
    output logic             overrun
);

    logic ref_stb, dut_stb, tmo_hit;
    logic ev_finish, ev_finish_ref, ev_tie, ev_expire;

    iv_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
        .clk(clk), .rst(rst), .async_in(ref_in), .rise_stb(ref_stb)
    );

    iv_edge_sync #(.STAGES(SYNC_STAGES)) u_dut_sync (
        .clk(clk), .rst(rst), .async_in(dut_in), .rise_stb(dut_stb)
    );

    iv_ctrl u_ctrl (
        .clk(clk), .rst(rst),
        .ref_stb(ref_stb), .dut_stb(dut_stb), .tmo_hit(tmo_hit),
        .gate(gate), .lead_ref(lead_ref), .lead_dut(lead_dut),
        .ev_finish(ev_finish), .ev_finish_ref(ev_finish_ref),
        .ev_tie(ev_tie), .ev_expire(ev_expire)
    );

    iv_span_cnt #(.CNT_W(CNT_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_cnt (
        .clk(clk), .rst(rst), .run(gate),
        .ev_finish(ev_finish), .ev_finish_ref(ev_finish_ref),
        .ev_tie(ev_tie), .ev_expire(ev_expire),
        .tmo_hit(tmo_hit), .span(span), .span_ref_led(span_ref_led),
        .span_valid(span_valid), .overrun(overrun)
    );

endmodule

// File: rtl/iv_meter_chk.sv
module iv_meter_chk #(
    parameter int          CNT_W       = 32,
    parameter int unsigned TIMEOUT_CYC = 32'd2250000000
) (
    input logic             clk,
    input logic             rst,
    input logic             gate,
    input logic             lead_ref,
    input logic             lead_dut,
    input logic [CNT_W-1:0] span,
    input logic             span_ref_led,
    input logic             span_valid,
    input logic             overrun
);

    localparam logic [CNT_W:0] TMO_L = (CNT_W+1)'(TIMEOUT_CYC);

    logic [CNT_W:0] open_cnt;

    always_ff @(posedge clk) begin
        if (rst || !gate) open_cnt <= '0;
        else              open_cnt <= open_cnt + 1'b1;
    end

    // R3
    lead_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({lead_ref, lead_dut}));

    // R3
    lead_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(lead_ref) || $fell(lead_dut)) |-> (!gate && (span_valid || overrun)));

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(span_valid && overrun));

    // R4
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        span_valid |=> !span_valid);

    // R7
    nonzero_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (span_valid && span != '0) |-> $past(gate));

    // R8
    gate_window_chk: assert property (@(posedge clk) disable iff (rst)
        gate |-> (open_cnt < TMO_L));

    // R8
    overrun_close_chk: assert property (@(posedge clk) disable iff (rst)
        overrun |-> (!gate && $past(gate) && $stable(span)));

    // R10
    span_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !span_valid |-> ($stable(span) && $stable(span_ref_led)));

endmodule

bind iv_meter iv_meter_chk #(.CNT_W(CNT_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
    .clk(clk), .rst(rst), .gate(gate), .lead_ref(lead_ref), .lead_dut(lead_dut),
    .span(span), .span_ref_led(span_ref_led), .span_valid(span_valid),
    .overrun(overrun)
);

// File: tb/iv_meter_tb.sv
module iv_meter_tb;

    localparam int CNT_W = 32;
    localparam int TMO   = 40;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ref_in = 1'b0;
    logic             dut_in = 1'b0;
    logic             gate, lead_ref, lead_dut, span_ref_led, span_valid, overrun;
    logic [CNT_W-1:0] span;

    int n_chk = 0;
    int n_err = 0;
    logic [CNT_W-1:0] last_span = '0;

    always #4 clk = ~clk;

    iv_meter #(.CNT_W(CNT_W), .TIMEOUT_CYC(TMO)) u_dut (
        .clk(clk), .rst(rst), .ref_in(ref_in), .dut_in(dut_in),
        .gate(gate), .lead_ref(lead_ref), .lead_dut(lead_dut),
        .span(span), .span_ref_led(span_ref_led),
        .span_valid(span_valid), .overrun(overrun)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic settle();
        @(negedge clk);
        ref_in = 1'b0;
        dut_in = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    // leader rises, other rises d cycles later (d >= 4)
    task automatic measure(input bit ref_first, input int d, input string req);
        @(negedge clk);
        if (ref_first) ref_in = 1'b1; else dut_in = 1'b1;
        step(3);
        chk(gate == 1'b0, "R2", "gate early", gate, 0);
        step(1);
        chk(gate == 1'b1, "R2", "gate open", gate, 1);
        chk(lead_ref == ref_first && lead_dut == !ref_first, "R3", "lead flag",
            {lead_ref, lead_dut}, ref_first ? 2 : 1);
        repeat (d - 3) @(negedge clk);
        if (ref_first) dut_in = 1'b1; else ref_in = 1'b1;
        step(3);
        chk(gate == 1'b1 && span_valid == 1'b0, "R2", "gate before close",
            {gate, span_valid}, 2);
        step(1);
        chk(span_valid == 1'b1, req, "valid", span_valid, 1);
        chk(span == d, "R4", "span", span, d);
        chk(span_ref_led == ref_first, "R5", "sign", span_ref_led, ref_first);
        chk(gate == 1'b0 && lead_ref == 1'b0 && lead_dut == 1'b0, "R3",
            "close flags", {gate, lead_ref, lead_dut}, 0);
        step(1);
        chk(span_valid == 1'b0 && span == d, "R10", "hold", span, d);
        last_span = span;
        settle();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        ref_in = 1'b1;
        dut_in = 1'b0;
        step(3);
        chk({gate, lead_ref, lead_dut, span_valid, overrun, span_ref_led} == 6'b0
            && span == '0, "R1", "outputs in reset", span, 0);
        @(negedge clk);
        rst = 1'b0;
        ref_in = 1'b0;
        step(1);
        chk({gate, lead_ref, lead_dut, span_valid, overrun} == 5'b0, "R1",
            "outputs after reset", {gate, span_valid}, 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_tie();
        @(negedge clk);
        ref_in = 1'b1;
        dut_in = 1'b1;
        step(3);
        chk(span_valid == 1'b0, "R7", "tie valid early", span_valid, 0);
        step(1);
        chk(span_valid == 1'b1 && span == '0, "R7", "tie span", span, 0);
        chk(gate == 1'b0 && lead_ref == 1'b0 && lead_dut == 1'b0
            && span_ref_led == 1'b0, "R7", "tie flags",
            {gate, lead_ref, lead_dut, span_ref_led}, 0);
        step(1);
        chk(span_valid == 1'b0 && gate == 1'b0, "R7", "tie one pulse",
            {span_valid, gate}, 0);
        last_span = span;
        settle();
    endtask

    // held levels, falling edges and a re-rise of the leader have no effect
    task automatic t_levels();
        int bad = 0;
        @(negedge clk);
        ref_in = 1'b1;
        repeat (6) @(negedge clk);
        ref_in = 1'b0;
        repeat (3) @(negedge clk);
        ref_in = 1'b1;
        repeat (3) @(negedge clk);
        dut_in = 1'b1;
        step(4);
        chk(span_valid == 1'b1 && span == 12, "R6", "re-rise ignored", span, 12);
        for (int i = 0; i < 20; i++) begin
            step(1);
            if (gate || span_valid || overrun) bad++;
        end
        chk(bad == 0, "R6", "held high no retrigger", bad, 0);
        @(negedge clk);
        dut_in = 1'b0;
        bad = 0;
        for (int i = 0; i < 10; i++) begin
            step(1);
            if (gate || span_valid) bad++;
        end
        chk(bad == 0, "R6", "falling edge ignored", bad, 0);
        last_span = span;
        settle();
    endtask

    task automatic t_timeout();
        @(negedge clk);
        ref_in = 1'b1;
        step(3 + TMO);
        chk(gate == 1'b1 && overrun == 1'b0, "R8", "gate at limit",
            {gate, overrun}, 2);
        step(1);
        chk(gate == 1'b0 && overrun == 1'b1, "R8", "forced close",
            {gate, overrun}, 1);
        chk(span_valid == 1'b0 && span == last_span, "R8", "span kept", span, last_span);
        step(1);
        chk(overrun == 1'b0, "R8", "overrun one pulse", overrun, 0);
        settle();
    endtask

    initial begin
        fork
            begin
                t_reset();
                measure(1'b1, 9, "R4");
                measure(1'b0, 5, "R4");
                measure(1'b1, 4, "R2");
                t_tie();
                t_levels();
                t_timeout();
                measure(1'b0, 7, "R9");
                measure(1'b1, 25, "R9");
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_err++;
                $display("FAIL watchdog: actual=hung expected=done");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule